// File: doc/BRIEF.md
# PCM Frame-Synchronised Serial Port

This block joins a 14-bit linear codec core to a serial PCM bus and runs both directions at once. A bit clock sets the pace, one data bit per period, and a frame sync pulse marks the start of each frame. Both of these come from the bus. The block samples them with its own faster system clock, so it never clocks logic on the bus signals directly.

On the receive side, the bit present on each falling bit-clock edge is shifted in, most significant bit first. The first bit counted is the one that follows a sync rising edge. After the fourteenth bit, the word is offered as a two's-complement sample on a valid/ready stream. On the transmit side, a sample taken from a valid/ready stream waits in a holding register until the next sync rising edge. It is then sent out most significant bit first on an open-drain line, which the block can only pull low or release. The line is released outside the 14-bit window and whenever the power enable is low.

Receive stream back-pressure: `rx_valid_o` stays high until `rx_ready_i` takes the word. If the next word completes before that, it replaces the older word in place. Transmit stream back-pressure: `tx_ready_o` is high only while the holding register is empty. A frame that starts with the holding register empty sends the zero code.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `rx_valid_o` is 0, `tx_ready_o` is 1, `sd_drv_o` is 0 and `sd_out_o` is 1.
- R2: The receiver samples `sd_in_i` on bit-clock falling edges. The first sample after a sync rising edge becomes bit 13 (the sign) of the word. After the fourteenth sample, the word appears on `rx_data_o` with `rx_valid_o` high. Codes are two's complement: 0x1FFF is positive full scale, 0x0001 is +1, 0x0000 is zero, 0x3FFF is -1 and 0x2000 is negative full scale.
- R3: `rx_valid_o` stays high until a cycle with `rx_ready_i` high. A word that completes while the previous one is still pending overwrites it. If a completion and an accept fall in the same cycle, the new word is kept and `rx_valid_o` stays high.
- R4: A sync rising edge puts bit 13 of the transmit word on the line. Each later bit-clock rising edge advances one bit toward bit 0. `sd_out_o` shows the current bit.
- R5: Open-drain output: `sd_drv_o` (pull line low) is high only inside the window and only while the current bit is 0. `sd_out_o` is 1 whenever the line is released.
- R6: The line is released before the first sync. It is released again at the fourteenth bit-clock rising edge after the sync that opened the window.
- R7: `tx_ready_o` is high exactly while the holding register is empty. An accepted word stays there until the next sync rising edge moves it to the shifter. If the register is empty at that edge, the frame sends 0x0000.
- R8: Received bits after the fourteenth in a frame are ignored. They change neither the word nor the strobe.
- R9: A sync rising edge restarts the bit count in both directions. A partly received word is dropped without asserting `rx_valid_o`.
- R10: With `pwr_en` low, the line is released within one system clock, no window opens and no received word is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Port power enable |
| bclk_i | input | 1 | Bus bit clock (sampled) |
| fsync_i | input | 1 | Bus frame sync (sampled) |
| sd_in_i | input | 1 | Serial receive data |
| sd_out_o | output | 1 | Current transmit bit, 1 when released |
| sd_drv_o | output | 1 | Open-drain pull-low enable |
| rx_data_o | output | 14 | Received sample, two's complement |
| rx_valid_o | output | 1 | Received sample valid |
| rx_ready_i | input | 1 | Consumer takes received sample |
| tx_data_i | input | 14 | Sample to transmit, two's complement |
| tx_valid_i | input | 1 | Transmit sample offered |
| tx_ready_o | output | 1 | Holding register empty |

## Verification
The receive path can finish a word in the same system cycle in which the consumer accepts the previous one. The bench provokes this by leaving a word pending, then raising `rx_ready_i` for exactly the one cycle in which the next frame's fourteenth falling edge leaves the synchronizer. It counts the registers from the pin to the strobe to find that cycle. The expected result is `rx_valid_o` still high with the newer word on `rx_data_o`. If the old word had survived, or if the strobe had dropped, the new sample would have been lost.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned PCM_W = 14;
  localparam int unsigned PCM_SYNC_STAGES = 2;
endpackage

// File: rtl/pcm_sync_chain.sv
module pcm_sync_chain #(
  parameter int unsigned STAGES = pcm_port_pkg::PCM_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign level_o = pipe[STAGES-1];
endmodule

// File: rtl/pcm_edge_detect.sv
module pcm_edge_detect #(
  parameter int unsigned STAGES = pcm_port_pkg::PCM_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o,
  output logic fall_o
);
  logic level;
  logic prev;

  pcm_sync_chain #(.STAGES(STAGES)) u_chain (
    .clk(clk), .rst_n(rst_n), .din(din), .level_o(level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign rise_o = level & ~prev;
  assign fall_o = ~level & prev;
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path #(
  parameter int unsigned W = pcm_port_pkg::PCM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         bit_fall_i,
  input  logic         frame_rise_i,
  input  logic         sd_bit_i,
  input  logic         rx_ready_i,
  output logic [W-1:0] rx_data_o,
  output logic         rx_valid_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic [W-1:0]  next_word;
  logic          load;

  assign next_word = {shreg[W-2:0], sd_bit_i};
  assign load = en_i && !frame_rise_i && bit_fall_i && (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= CW'(W);
    end else if (!en_i) begin
      cnt <= CW'(W);
    end else if (frame_rise_i) begin
      if (bit_fall_i) begin
        shreg <= next_word;
        cnt   <= CW'(1);
      end else begin
        cnt <= '0;
      end
    end else if (bit_fall_i && (cnt < CW'(W))) begin
      shreg <= next_word;
      cnt   <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else if (load) begin
      rx_data_o  <= next_word;
      rx_valid_o <= 1'b1;
    end else if (rx_valid_o && rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
  parameter int unsigned W = pcm_port_pkg::PCM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         bit_rise_i,
  input  logic         frame_rise_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_valid_i,
  output logic         tx_ready_o,
  output logic         sd_bit_o,
  output logic         win_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  hold;
  logic          full;
  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          start;

  assign accept = tx_valid_i && !full;
  assign start  = en_i && frame_rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      full <= 1'b0;
    end else if (accept) begin
      hold <= tx_data_i;
      full <= 1'b1;
    end else if (start) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      win_o <= 1'b0;
      cnt   <= '0;
    end else if (start) begin
      shreg <= full ? hold : '0;
      win_o <= 1'b1;
      cnt   <= '0;
    end else if (!en_i) begin
      win_o <= 1'b0;
    end else if (win_o && bit_rise_i) begin
      if (cnt == CW'(W - 1)) begin
        win_o <= 1'b0;
      end else begin
        cnt   <= cnt + CW'(1);
        shreg <= {shreg[W-2:0], 1'b0};
      end
    end
  end

  assign tx_ready_o = !full;
  assign sd_bit_o   = shreg[W-1];
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int unsigned SAMPLE_W    = pcm_port_pkg::PCM_W,
  parameter int unsigned SYNC_STAGES = pcm_port_pkg::PCM_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pwr_en,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic                sd_in_i,
  output logic                sd_out_o,
  output logic                sd_drv_o,
  output logic [SAMPLE_W-1:0] rx_data_o,
  output logic                rx_valid_o,
  input  logic                rx_ready_i,
  input  logic [SAMPLE_W-1:0] tx_data_i,
  input  logic                tx_valid_i,
  output logic                tx_ready_o
);
  logic bclk_rise, bclk_fall;
  logic fs_level, fs_prev, fs_rise;
  logic sd_level;
  logic tx_bit, tx_win;

  pcm_edge_detect #(.STAGES(SYNC_STAGES)) u_bclk (
    .clk(clk), .rst_n(rst_n), .din(bclk_i),
    .rise_o(bclk_rise), .fall_o(bclk_fall)
  );

  pcm_sync_chain #(.STAGES(SYNC_STAGES)) u_fsync (
    .clk(clk), .rst_n(rst_n), .din(fsync_i), .level_o(fs_level)
  );

  pcm_sync_chain #(.STAGES(SYNC_STAGES)) u_sdin (
    .clk(clk), .rst_n(rst_n), .din(sd_in_i), .level_o(sd_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fs_prev <= 1'b0;
    else        fs_prev <= fs_level;
  end
  assign fs_rise = fs_level & ~fs_prev;

  pcm_rx_path #(.W(SAMPLE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(pwr_en),
    .bit_fall_i(bclk_fall), .frame_rise_i(fs_rise), .sd_bit_i(sd_level),
    .rx_ready_i(rx_ready_i), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  pcm_tx_path #(.W(SAMPLE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en_i(pwr_en),
    .bit_rise_i(bclk_rise), .frame_rise_i(fs_rise),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .sd_bit_o(tx_bit), .win_o(tx_win)
  );

  assign sd_drv_o = tx_win & ~tx_bit;
  assign sd_out_o = tx_win ? tx_bit : 1'b1;
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
  parameter int unsigned SAMPLE_W = pcm_port_pkg::PCM_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                pwr_en,
  input logic                sd_out_o,
  input logic                sd_drv_o,
  input logic [SAMPLE_W-1:0] rx_data_o,
  input logic                rx_valid_o,
  input logic                rx_ready_i,
  input logic                tx_valid_i,
  input logic                tx_ready_o
);
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o);

  p_drive_low_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sd_drv_o |-> !sd_out_o);

  p_accept_fills_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  p_off_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !sd_drv_o);

  p_no_strobe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid_o) |-> $past(pwr_en));
endmodule

bind pcm_serial_port pcm_serial_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
  .sd_out_o(sd_out_o), .sd_drv_o(sd_drv_o),
  .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
  .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o)
);

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_en = 1'b1;
  logic bclk = 1'b0;
  logic fsync = 1'b0;
  logic sd_in = 1'b0;
  logic sd_out_o, sd_drv_o;
  logic [13:0] rx_data_o;
  logic rx_valid_o;
  logic rx_ready = 1'b0;
  logic [13:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcm_serial_port i_pcm_serial_port (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en),
    .bclk_i(bclk), .fsync_i(fsync), .sd_in_i(sd_in),
    .sd_out_o(sd_out_o), .sd_drv_o(sd_drv_o),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready_o)
  );

  // {receive word, transmit word}
  localparam logic [27:0] VEC [6] = '{
    {14'h1FFF, 14'h2000},
    {14'h0001, 14'h3FFF},
    {14'h0000, 14'h1FFF},
    {14'h3FFF, 14'h0001},
    {14'h2000, 14'h0000},
    {14'h2AAA, 14'h1555}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [13:0] w);
    @(negedge clk);
    tx_data  = w;
    tx_valid = 1'b1;
    while (!tx_ready_o) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // txmode: 0 no line check, 1 expect word, 2 expect released
  task automatic frame(input logic [13:0] rxw, input int nbits, input int txmode,
                       input logic [13:0] txw, input bit collide, input bit chk_end);
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      bclk  = 1'b1;
      fsync = (k == 0);
      sd_in = (k < 14) ? rxw[13-k] : ~rxw[k-14];
      repeat (5) @(negedge clk);
      if (txmode == 1 && k < 14)
        check(sd_drv_o == ~txw[13-k] && sd_out_o == txw[13-k], "R4/R5",
              int'({sd_out_o, sd_drv_o}), int'({txw[13-k], ~txw[13-k]}));
      if (txmode == 2)
        check(!sd_drv_o && sd_out_o, "R10", int'({sd_out_o, sd_drv_o}), 2);
      bclk = 1'b0;
      if (collide && k == nbits - 1) begin
        repeat (2) @(negedge clk);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        repeat (2) @(negedge clk);
      end else begin
        repeat (5) @(negedge clk);
      end
    end
    @(negedge clk);
    bclk  = 1'b1;
    fsync = 1'b0;
    repeat (5) @(negedge clk);
    if (chk_end || txmode == 2)
      check(!sd_drv_o && sd_out_o, "R6", int'({sd_out_o, sd_drv_o}), 2);
    bclk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic take_rx(input logic [13:0] w, input string req);
    check(rx_valid_o && rx_data_o == w, req, int'({rx_valid_o, rx_data_o}), int'({1'b1, w}));
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(!rx_valid_o, "R3", int'(rx_valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!rx_valid_o, "R1", int'(rx_valid_o), 0);
    check(tx_ready_o, "R1", int'(tx_ready_o), 1);
    check(!sd_drv_o && sd_out_o, "R1", int'({sd_out_o, sd_drv_o}), 2);

    // R2 / R4 / R5 / R6 table walk
    foreach (VEC[i]) begin
      push(VEC[i][13:0]);
      frame(VEC[i][27:14], 14, 1, VEC[i][13:0], 1'b0, 1'b1);
      take_rx(VEC[i][27:14], "R2");
    end

    // R7 empty holding register sends zero
    check(tx_ready_o, "R7", int'(tx_ready_o), 1);
    frame(14'h0F0F, 14, 1, 14'h0000, 1'b0, 1'b1);
    take_rx(14'h0F0F, "R2");

    // R7 accepted word waits for the sync; R6 line idle meanwhile
    push(14'h3A5C);
    check(!tx_ready_o, "R7", int'(tx_ready_o), 0);
    repeat (20) @(negedge clk);
    check(!tx_ready_o, "R7", int'(tx_ready_o), 0);
    check(!sd_drv_o && sd_out_o, "R6", int'({sd_out_o, sd_drv_o}), 2);
    frame(14'h1234, 14, 1, 14'h3A5C, 1'b0, 1'b1);
    check(tx_ready_o, "R7", int'(tx_ready_o), 1);
    take_rx(14'h1234, "R2");

    // R8 extra bits ignored
    push(14'h2DB6);
    frame(14'h0C3F, 17, 1, 14'h2DB6, 1'b0, 1'b1);
    take_rx(14'h0C3F, "R8");

    // R9 early restart drops partial word
    push(14'h1111);
    frame(14'h3E00, 5, 0, 14'h0000, 1'b0, 1'b0);
    check(!rx_valid_o, "R9", int'(rx_valid_o), 0);
    push(14'h2222);
    frame(14'h05A5, 14, 1, 14'h2222, 1'b0, 1'b1);
    take_rx(14'h05A5, "R9");

    // R3 overwrite while pending, then completion and accept in one cycle
    frame(14'h0AAA, 14, 0, 14'h0000, 1'b0, 1'b0);
    check(rx_valid_o && rx_data_o == 14'h0AAA, "R3", int'(rx_data_o), 14'h0AAA);
    frame(14'h1BBB, 14, 0, 14'h0000, 1'b0, 1'b0);
    check(rx_valid_o && rx_data_o == 14'h1BBB, "R3", int'(rx_data_o), 14'h1BBB);
    frame(14'h2CCC, 14, 0, 14'h0000, 1'b1, 1'b0);
    take_rx(14'h2CCC, "R3");

    // R10 powered down: no window, no strobe
    @(negedge clk);
    pwr_en = 1'b0;
    frame(14'h1357, 14, 2, 14'h0000, 1'b0, 1'b0);
    check(!rx_valid_o, "R10", int'(rx_valid_o), 0);
    pwr_en = 1'b1;
    frame(14'h2468, 14, 1, 14'h0000, 1'b0, 1'b1);
    take_rx(14'h2468, "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule